// File: doc/BRIEF.md
# Calendar Alarm Match and Repeat Controller

This block sits beside a real-time clock and decides when an alarm goes off. The clock's counters are outside the block. They arrive as BCD fields for seconds, minutes, hours, weekday, day and month, together with a half-second phase bit and a one-cycle strobe that marks each half-second step. Software writes six alarm fields and a 4-bit granularity code. On the clock cycle after a strobe whose time agrees with the alarm at the chosen granularity, the block raises a single-cycle event. The granularity runs from every half second up to once a year. A yearly alarm set to 29 February fires only in years that contain that date.

A repeat counter limits how many times the alarm fires. Each event lowers the counter by one, and at zero the enable bit clears itself. In chime mode the counter wraps from zero to its top value, so the alarm keeps firing. The alarm fields are reached through a two-byte window. A 2-bit pointer picks the field pair, and the pointer steps down toward zero after each access to the high byte. Software can therefore write or read all six fields by setting the pointer once and then making three pairs of accesses.

The sequencer has three states. OFF means disarmed. ARMED means waiting for a match. FIRE is the single cycle in which the event is driven. The transitions are:
- OFF→ARMED: a configuration write with enable set.
- ARMED→FIRE: a strobe with a match and no configuration write.
- ARMED→OFF: a configuration write with enable clear.
- FIRE→ARMED: counter not exhausted, or chime on.
- FIRE→OFF: auto-clear.
- Any state→OFF or ARMED: a configuration write, which always follows the written enable bit.

Top module: `rtc_alarm_ctrl`

## Requirements
- R1: After reset, cfg_rdata reads 0 (disabled, chime off, pointer 0, granularity 0, counter 0), both window bytes read 0 and alarm_evt is low.
- R2: alarm_evt is high for exactly one cycle. It is high in the cycle after a cycle with tick_half high, a match, the alarm enabled and no cfg_wr. It is never high without such a strobe, even if the time keeps matching.
- R3: Granularity 0 matches on every strobe. Granularity 1 matches on strobes with now_half = 0, regardless of the time fields.
- R4: With now_half = 0, the following fields must match. Granularity 2: the low BCD digit of seconds. Granularity 3: all of seconds. Granularity 4: seconds plus the low digit of minutes. Granularity 5: seconds and minutes.
- R5: With now_half = 0, the following fields must match. Granularity 6: seconds, minutes and hours. Granularity 7: those plus weekday. Granularity 8: seconds, minutes, hours and day. Granularity 9: those plus month. An alarm of month 02, day 29 therefore matches only on that date.
- R6: Granularity codes 10 to 15 never produce an event.
- R7: An event with a nonzero counter lowers the counter by one and keeps the alarm enabled.
- R8: An event with the counter at 0 and chime on sets the counter to FFh and keeps the alarm enabled.
- R9: An event with the counter at 0 and chime off leaves the counter at 0 and clears enable, so no further events occur.
- R10: Pointer 0 shows minutes (high byte) and seconds (low byte). Pointer 1 shows weekday (high) and hours (low). Pointer 2 shows month (high) and day (low). A window write stores into the field that is shown.
- R11: Each high-byte read or write lowers the pointer by one, down to 0, where it stays. A low-byte write leaves the pointer unchanged.
- R12: At pointer 3, both window bytes read 0 and writes change no field. A high-byte access still lowers the pointer to 2.
- R13: A configuration write takes effect in full on the next cycle. It overrides both the counter update of a FIRE cycle and a pointer step in the same cycle. The cfg word is {enable[15], chime[14], pointer[13:12], granularity[11:8], counter[7:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_half | input | 1 | One-cycle strobe for each half-second time step |
| now_half | input | 1 | Half-second phase of the live time, 0 in the first half of a second |
| now_sec | input | 8 | Live seconds, BCD |
| now_min | input | 8 | Live minutes, BCD |
| now_hour | input | 8 | Live hours, BCD |
| now_wday | input | 8 | Live weekday code |
| now_day | input | 8 | Live day of month, BCD |
| now_month | input | 8 | Live month, BCD |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Current configuration word |
| win_hi_wr | input | 1 | High window byte write |
| win_hi_rd | input | 1 | High window byte read (pointer step) |
| win_lo_wr | input | 1 | Low window byte write |
| win_wdata | input | 8 | Window write data |
| win_hi_rdata | output | 8 | High window byte |
| win_lo_rdata | output | 8 | Low window byte |
| alarm_evt | output | 1 | Single-cycle alarm event |

## Verification
The assertions check, on every cycle, the rules that act on one event or one access:
- the event is one cycle wide, follows a strobe and stays silent under reserved codes;
- the counter decrements, wraps or auto-clears as the rules say;
- the pointer steps down and stops at its floor, and reads 0 at position 3;
- a configuration write wins.

Whether the right fields are compared at each granularity, including the 29 February case, can only be shown by the bench's scenarios. The same holds for correct window-to-field mapping and for the effect of writes at pointer 3. The bench drives directed and seeded random times against a reference match function.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int FLD_W  = 8;   // one BCD byte per time field
    localparam int DIG_W  = 4;   // one BCD digit
    localparam int PTR_W  = 2;   // window pointer width
    localparam int NPAIR  = 3;   // implemented field pairs behind the window
    localparam int MASK_W = 4;   // granularity code width

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } alm_state_e;

    typedef enum logic [MASK_W-1:0] {
        GR_HALF   = 4'd0,
        GR_SEC    = 4'd1,
        GR_TENSEC = 4'd2,
        GR_MIN    = 4'd3,
        GR_TENMIN = 4'd4,
        GR_HOUR   = 4'd5,
        GR_DAY    = 4'd6,
        GR_WEEK   = 4'd7,
        GR_MONTH  = 4'd8,
        GR_YEAR   = 4'd9
    } alm_gran_e;

    typedef struct packed {
        logic [FLD_W-1:0] sec;
        logic [FLD_W-1:0] min;
        logic [FLD_W-1:0] hour;
        logic [FLD_W-1:0] wday;
        logic [FLD_W-1:0] day;
        logic [FLD_W-1:0] month;
    } cal_time_t;

endpackage

// File: rtl/rtc_alarm_window.sv
module rtc_alarm_window
    import rtc_alarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_load,
    input  logic [PTR_W-1:0] ptr_din,
    input  logic             hi_wr,
    input  logic             hi_rd,
    input  logic             lo_wr,
    input  logic [FLD_W-1:0] wdata,
    output logic [PTR_W-1:0] ptr,
    output logic [FLD_W-1:0] hi_rdata,
    output logic [FLD_W-1:0] lo_rdata,
    output cal_time_t        alarm
);

    logic [FLD_W-1:0] hi_vec [NPAIR];
    logic [FLD_W-1:0] lo_vec [NPAIR];
    logic             hi_access;

    assign hi_access = hi_wr | hi_rd;

    // Pointer: a configuration load wins, otherwise step down to the floor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr_load) begin
            ptr <= ptr_din;
        end else if (hi_access && (ptr != '0)) begin
            ptr <= ptr - 1'b1;
        end
    end

    // One storage pair per implemented pointer value
    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        logic [FLD_W-1:0] hi_q;
        logic [FLD_W-1:0] lo_q;
        logic             sel;

        assign sel = (ptr == PTR_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_q <= '0;
                lo_q <= '0;
            end else begin
                if (hi_wr && sel) hi_q <= wdata;
                if (lo_wr && sel) lo_q <= wdata;
            end
        end

        assign hi_vec[g] = hi_q;
        assign lo_vec[g] = lo_q;
    end

    // Read mux: an unimplemented pointer value reads as zero
    always_comb begin
        hi_rdata = '0;
        lo_rdata = '0;
        for (int i = 0; i < NPAIR; i++) begin
            if (ptr == PTR_W'(i)) begin
                hi_rdata = hi_vec[i];
                lo_rdata = lo_vec[i];
            end
        end
    end

    assign alarm.sec   = lo_vec[0];
    assign alarm.min   = hi_vec[0];
    assign alarm.hour  = lo_vec[1];
    assign alarm.wday  = hi_vec[1];
    assign alarm.day   = lo_vec[2];
    assign alarm.month = hi_vec[2];

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic [MASK_W-1:0] gran,
    input  logic              now_half,
    input  cal_time_t         now,
    input  cal_time_t         alarm,
    output logic              hit
);

    logic on_sec;
    logic sec_lo, sec_eq, min_lo, min_eq, hour_eq, wday_eq, day_eq, mon_eq;
    logic upto_min;

    always_comb begin
        on_sec   = ~now_half;
        sec_lo   = (now.sec[DIG_W-1:0] == alarm.sec[DIG_W-1:0]);
        sec_eq   = (now.sec   == alarm.sec);
        min_lo   = (now.min[DIG_W-1:0] == alarm.min[DIG_W-1:0]);
        min_eq   = (now.min   == alarm.min);
        hour_eq  = (now.hour  == alarm.hour);
        wday_eq  = (now.wday  == alarm.wday);
        day_eq   = (now.day   == alarm.day);
        mon_eq   = (now.month == alarm.month);
        upto_min = on_sec & sec_eq & min_eq;
    end

    always_comb begin
        unique case (alm_gran_e'(gran))
            GR_HALF:   hit = 1'b1;
            GR_SEC:    hit = on_sec;
            GR_TENSEC: hit = on_sec & sec_lo;
            GR_MIN:    hit = on_sec & sec_eq;
            GR_TENMIN: hit = on_sec & sec_eq & min_lo;
            GR_HOUR:   hit = upto_min;
            GR_DAY:    hit = upto_min & hour_eq;
            GR_WEEK:   hit = upto_min & hour_eq & wday_eq;
            GR_MONTH:  hit = upto_min & hour_eq & day_eq;
            GR_YEAR:   hit = upto_min & hour_eq & day_eq & mon_eq;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_alarm_seq.sv
module rtc_alarm_seq
    import rtc_alarm_pkg::*;
#(
    parameter int RPT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic              cfg_chime,
    input  logic [MASK_W-1:0] cfg_gran,
    input  logic [RPT_W-1:0]  cfg_rpt,
    input  logic              tick,
    input  logic              hit,
    output logic              en,
    output logic              chime,
    output logic [MASK_W-1:0] gran,
    output logic [RPT_W-1:0]  rpt,
    output logic              evt
);

    alm_state_e state, nxt;
    logic       rpt_zero;

    assign rpt_zero = (rpt == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   nxt = ST_OFF;
            ST_ARMED: nxt = (tick && hit) ? ST_FIRE : ST_ARMED;
            ST_FIRE:  nxt = (rpt_zero && !chime) ? ST_OFF : ST_ARMED;
            default:  nxt = ST_OFF;
        endcase
        if (cfg_wr) nxt = cfg_en ? ST_ARMED : ST_OFF;
    end

    // Outputs
    always_comb begin
        evt = (state == ST_FIRE);
        en  = (state != ST_OFF);
    end

    // Repeat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpt <= '0;
        end else if (cfg_wr) begin
            rpt <= cfg_rpt;
        end else if (state == ST_FIRE) begin
            if (!rpt_zero)  rpt <= rpt - 1'b1;
            else if (chime) rpt <= '1;
        end
    end

    // Mode bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chime <= 1'b0;
            gran  <= '0;
        end else if (cfg_wr) begin
            chime <= cfg_chime;
            gran  <= cfg_gran;
        end
    end

endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
    import rtc_alarm_pkg::*;
#(
    parameter int RPT_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tick_half,
    input  logic                              now_half,
    input  logic [FLD_W-1:0]                  now_sec,
    input  logic [FLD_W-1:0]                  now_min,
    input  logic [FLD_W-1:0]                  now_hour,
    input  logic [FLD_W-1:0]                  now_wday,
    input  logic [FLD_W-1:0]                  now_day,
    input  logic [FLD_W-1:0]                  now_month,
    input  logic                              cfg_wr,
    input  logic [RPT_W+MASK_W+PTR_W+1:0]     cfg_wdata,
    output logic [RPT_W+MASK_W+PTR_W+1:0]     cfg_rdata,
    input  logic                              win_hi_wr,
    input  logic                              win_hi_rd,
    input  logic                              win_lo_wr,
    input  logic [FLD_W-1:0]                  win_wdata,
    output logic [FLD_W-1:0]                  win_hi_rdata,
    output logic [FLD_W-1:0]                  win_lo_rdata,
    output logic                              alarm_evt
);

    localparam int CFG_W   = RPT_W + MASK_W + PTR_W + 2;
    localparam int EN_BIT  = CFG_W - 1;
    localparam int CH_BIT  = CFG_W - 2;
    localparam int PTR_LSB = RPT_W + MASK_W;

    cal_time_t         now_t;
    cal_time_t         alarm_t;
    logic [PTR_W-1:0]  ptr;
    logic              hit;
    logic              en, chime;
    logic [MASK_W-1:0] gran;
    logic [RPT_W-1:0]  rpt;

    assign now_t.sec   = now_sec;
    assign now_t.min   = now_min;
    assign now_t.hour  = now_hour;
    assign now_t.wday  = now_wday;
    assign now_t.day   = now_day;
    assign now_t.month = now_month;

    rtc_alarm_window u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_load (cfg_wr),
        .ptr_din  (cfg_wdata[PTR_LSB +: PTR_W]),
        .hi_wr    (win_hi_wr),
        .hi_rd    (win_hi_rd),
        .lo_wr    (win_lo_wr),
        .wdata    (win_wdata),
        .ptr      (ptr),
        .hi_rdata (win_hi_rdata),
        .lo_rdata (win_lo_rdata),
        .alarm    (alarm_t)
    );

    rtc_alarm_match u_match (
        .gran     (gran),
        .now_half (now_half),
        .now      (now_t),
        .alarm    (alarm_t),
        .hit      (hit)
    );

    rtc_alarm_seq #(.RPT_W(RPT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_en    (cfg_wdata[EN_BIT]),
        .cfg_chime (cfg_wdata[CH_BIT]),
        .cfg_gran  (cfg_wdata[RPT_W +: MASK_W]),
        .cfg_rpt   (cfg_wdata[RPT_W-1:0]),
        .tick      (tick_half),
        .hit       (hit),
        .en        (en),
        .chime     (chime),
        .gran      (gran),
        .rpt       (rpt),
        .evt       (alarm_evt)
    );

    assign cfg_rdata = {en, chime, ptr, gran, rpt};

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
    import rtc_alarm_pkg::*;
#(
    parameter int RPT_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tick_half,
    input logic                          cfg_wr,
    input logic [RPT_W+MASK_W+PTR_W+1:0] cfg_wdata,
    input logic [RPT_W+MASK_W+PTR_W+1:0] cfg_rdata,
    input logic                          win_hi_wr,
    input logic                          win_hi_rd,
    input logic [FLD_W-1:0]              win_hi_rdata,
    input logic [FLD_W-1:0]              win_lo_rdata,
    input logic                          alarm_evt
);

    localparam int CFG_W = RPT_W + MASK_W + PTR_W + 2;

    logic              c_en, c_ch;
    logic [PTR_W-1:0]  c_ptr;
    logic [MASK_W-1:0] c_gran;
    logic [RPT_W-1:0]  c_rpt;
    logic              c_hiacc;

    assign c_en    = cfg_rdata[CFG_W-1];
    assign c_ch    = cfg_rdata[CFG_W-2];
    assign c_ptr   = cfg_rdata[RPT_W+MASK_W +: PTR_W];
    assign c_gran  = cfg_rdata[RPT_W +: MASK_W];
    assign c_rpt   = cfg_rdata[RPT_W-1:0];
    assign c_hiacc = win_hi_wr | win_hi_rd;

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> !alarm_evt); // R2
    AST_EVT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> $past(tick_half)); // R2
    AST_RSV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (c_gran >= 4'd10 && !cfg_wr) |=> !alarm_evt); // R6
    AST_RPT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_evt && c_rpt != '0 && !cfg_wr) |=> (c_rpt == $past(c_rpt) - 1'b1) && c_en); // R7
    AST_CHIME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_evt && c_rpt == '0 && c_ch && !cfg_wr) |=> (c_rpt == '1) && c_en); // R8
    AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_evt && c_rpt == '0 && !c_ch && !cfg_wr) |=> !c_en && (c_rpt == '0)); // R9
    AST_PTR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ptr == '0 && c_hiacc && !cfg_wr) |=> c_ptr == '0); // R11
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ptr != '0 && c_hiacc && !cfg_wr) |=> c_ptr == $past(c_ptr) - 2'd1); // R11
    AST_PTR3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ptr == 2'd3) |-> (win_hi_rdata == '0 && win_lo_rdata == '0)); // R12
    AST_CFG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cfg_rdata == $past(cfg_wdata)); // R13

endmodule

bind rtc_alarm_ctrl rtc_alarm_chk #(.RPT_W(RPT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_half    (tick_half),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .win_hi_wr    (win_hi_wr),
    .win_hi_rd    (win_hi_rd),
    .win_hi_rdata (win_hi_rdata),
    .win_lo_rdata (win_lo_rdata),
    .alarm_evt    (alarm_evt)
);

// File: tb/rtc_alarm_ctrl_tb.sv
module rtc_alarm_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_half = 1'b0;
    logic        now_half = 1'b0;
    logic [7:0]  now_sec = '0, now_min = '0, now_hour = '0;
    logic [7:0]  now_wday = '0, now_day = '0, now_month = '0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        win_hi_wr = 1'b0, win_hi_rd = 1'b0, win_lo_wr = 1'b0;
    logic [7:0]  win_wdata = '0;
    logic [7:0]  win_hi_rdata, win_lo_rdata;
    logic        alarm_evt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_alarm_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick_half(tick_half), .now_half(now_half),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_wday(now_wday), .now_day(now_day), .now_month(now_month),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .win_hi_wr(win_hi_wr), .win_hi_rd(win_hi_rd), .win_lo_wr(win_lo_wr),
        .win_wdata(win_wdata), .win_hi_rdata(win_hi_rdata),
        .win_lo_rdata(win_lo_rdata), .alarm_evt(alarm_evt)
    );

    // Bench model
    bit         m_en, m_ch;
    logic [1:0] m_ptr;
    logic [3:0] m_gran;
    logic [7:0] m_rpt;
    logic [7:0] m_hi [4];
    logic [7:0] m_lo [4];
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_cfg(input string tag);
        chk(tag, cfg_rdata, {m_en, m_ch, m_ptr, m_gran, m_rpt});
    endtask

    function automatic bit ref_match(input logic [3:0] g, input logic h);
        bit s_lo, s_eq, mi_lo, mi_eq, hr, wd, dy, mo;
        s_lo  = now_sec[3:0] == m_lo[0][3:0];
        s_eq  = now_sec == m_lo[0];
        mi_lo = now_min[3:0] == m_hi[0][3:0];
        mi_eq = now_min == m_hi[0];
        hr    = now_hour == m_lo[1];
        wd    = now_wday == m_hi[1];
        dy    = now_day == m_lo[2];
        mo    = now_month == m_hi[2];
        case (g)
            4'd0: return 1'b1;
            4'd1: return !h;
            4'd2: return !h && s_lo;
            4'd3: return !h && s_eq;
            4'd4: return !h && s_eq && mi_lo;
            4'd5: return !h && s_eq && mi_eq;
            4'd6: return !h && s_eq && mi_eq && hr;
            4'd7: return !h && s_eq && mi_eq && hr && wd;
            4'd8: return !h && s_eq && mi_eq && hr && dy;
            4'd9: return !h && s_eq && mi_eq && hr && dy && mo;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] rbcd(input int top);
        int v;
        v = $urandom_range(0, top);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic cfg_set(input bit en, input bit ch, input logic [1:0] p,
                           input logic [3:0] g, input logic [7:0] r);
        cfg_wdata = {en, ch, p, g, r};
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_en = en; m_ch = ch; m_ptr = p; m_gran = g; m_rpt = r;
    endtask

    task automatic hi_acc(input bit wr, input logic [7:0] d, input string tag);
        if (!wr) begin
            #1;
            chk(tag, {8'h0, win_hi_rdata}, {8'h0, m_hi[m_ptr]});
        end
        win_hi_wr = wr; win_hi_rd = !wr; win_wdata = d;
        @(negedge clk);
        win_hi_wr = 1'b0; win_hi_rd = 1'b0;
        if (wr && m_ptr != 2'd3) m_hi[m_ptr] = d;
        if (m_ptr != 2'd0) m_ptr = m_ptr - 2'd1;
    endtask

    task automatic lo_write(input logic [7:0] d);
        win_lo_wr = 1'b1; win_wdata = d;
        @(negedge clk);
        win_lo_wr = 1'b0;
        if (m_ptr != 2'd3) m_lo[m_ptr] = d;
    endtask

    task automatic lo_chk(input string tag);
        #1;
        chk(tag, {8'h0, win_lo_rdata}, {8'h0, m_lo[m_ptr]});
    endtask

    task automatic set_alarm(input logic [7:0] s, mi, h, w, d, mo);
        cfg_set(m_en, m_ch, 2'd2, m_gran, m_rpt);
        lo_write(d);  hi_acc(1'b1, mo, "");
        lo_write(h);  hi_acc(1'b1, w, "");
        lo_write(s);  hi_acc(1'b1, mi, "");
    endtask

    task automatic set_now(input logic [7:0] s, mi, h, w, d, mo, input logic hf);
        now_sec = s; now_min = mi; now_hour = h;
        now_wday = w; now_day = d; now_month = mo; now_half = hf;
    endtask

    task automatic do_tick(input string tag);
        bit exp;
        exp = m_en && ref_match(m_gran, now_half);
        tick_half = 1'b1;
        @(negedge clk);
        tick_half = 1'b0;
        chk(tag, {15'h0, alarm_evt}, {15'h0, exp});
        @(negedge clk);
        chk(tag, {15'h0, alarm_evt}, 16'h0);
        if (exp) begin
            if (m_rpt != 8'h00)  m_rpt = m_rpt - 8'h01;
            else if (m_ch)       m_rpt = 8'hFF;
            else                 m_en = 1'b0;
        end
        chk_cfg(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL WDOG actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] f [6];
        void'($urandom(32'd5150));
        m_en = 0; m_ch = 0; m_ptr = 0; m_gran = 0; m_rpt = 0;
        for (int i = 0; i < 4; i++) begin m_hi[i] = '0; m_lo[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", cfg_rdata, 16'h0000);
        chk("R1", {win_hi_rdata, win_lo_rdata}, 16'h0000);
        chk("R1", {15'h0, alarm_evt}, 16'h0);

        // R10 / R11: fill the window and read it back
        set_alarm(8'h30, 8'h15, 8'h07, 8'h03, 8'h29, 8'h02);
        chk_cfg("R11");
        cfg_set(1'b0, 1'b0, 2'd2, 4'd0, 8'd0);
        lo_chk("R10");
        lo_write(8'h29);
        chk_cfg("R11");               // low write leaves pointer at 2
        hi_acc(1'b0, 8'h00, "R10");   // month
        chk_cfg("R11");
        lo_chk("R10");                // hour
        hi_acc(1'b0, 8'h00, "R10");   // weekday
        lo_chk("R10");                // seconds
        hi_acc(1'b0, 8'h00, "R10");   // minutes
        chk_cfg("R11");
        hi_acc(1'b0, 8'h00, "R11");   // floor at 0
        chk_cfg("R11");

        // R12: pointer 3 reads zero and ignores writes
        cfg_set(1'b0, 1'b0, 2'd3, 4'd0, 8'd0);
        #1 chk("R12", {win_hi_rdata, win_lo_rdata}, 16'h0000);
        lo_write(8'hA5);
        hi_acc(1'b1, 8'h5A, "R12");
        chk_cfg("R12");               // stepped to 2
        lo_chk("R12"); hi_acc(1'b0, 8'h00, "R12");
        lo_chk("R12"); hi_acc(1'b0, 8'h00, "R12");
        lo_chk("R12"); hi_acc(1'b0, 8'h00, "R12");

        // R2: matching time without a strobe gives nothing
        cfg_set(1'b1, 1'b0, 2'd0, 4'd3, 8'd9);
        set_now(8'h30, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 1'b0);
        repeat (4) begin
            @(negedge clk);
            chk("R2", {15'h0, alarm_evt}, 16'h0);
        end
        do_tick("R2");
        cfg_set(1'b0, 1'b0, 2'd0, 4'd3, 8'd9);
        do_tick("R2");                // disabled: no event

        // R3: half-second and one-second codes
        cfg_set(1'b1, 1'b0, 2'd0, 4'd0, 8'd5);
        set_now(8'h11, 8'h22, 8'h12, 8'h05, 8'h17, 8'h09, 1'b1);
        do_tick("R3");
        cfg_set(1'b1, 1'b0, 2'd0, 4'd1, 8'd5);
        do_tick("R3");
        now_half = 1'b0;
        do_tick("R3");

        // R5: February 29 in yearly mode
        cfg_set(1'b1, 1'b0, 2'd0, 4'd9, 8'd5);
        set_now(8'h30, 8'h15, 8'h07, 8'h06, 8'h28, 8'h02, 1'b0);
        do_tick("R5");
        set_now(8'h30, 8'h15, 8'h07, 8'h00, 8'h29, 8'h02, 1'b0);
        do_tick("R5");
        set_now(8'h30, 8'h15, 8'h07, 8'h01, 8'h01, 8'h03, 1'b0);
        do_tick("R5");

        // R7 / R9: counted repeats then auto-clear
        cfg_set(1'b1, 1'b0, 2'd0, 4'd0, 8'd2);
        do_tick("R7");
        do_tick("R7");
        do_tick("R9");
        do_tick("R9");
        // R8: chime wrap
        cfg_set(1'b1, 1'b1, 2'd0, 4'd0, 8'd0);
        do_tick("R8");
        do_tick("R8");

        // R13: configuration write during the event cycle wins
        cfg_set(1'b1, 1'b0, 2'd0, 4'd0, 8'd0);
        tick_half = 1'b1;
        @(negedge clk);
        tick_half = 1'b0;
        chk("R13", {15'h0, alarm_evt}, 16'h1);
        cfg_wdata = {1'b1, 1'b0, 2'd1, 4'd0, 8'h05};
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_en = 1; m_ch = 0; m_ptr = 2'd1; m_gran = 0; m_rpt = 8'h05;
        chk("R13", {15'h0, alarm_evt}, 16'h0);
        chk_cfg("R13");
        // R13: configuration write beats a pointer step
        cfg_wdata = {1'b0, 1'b0, 2'd3, 4'd0, 8'h00};
        cfg_wr = 1'b1; win_hi_rd = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; win_hi_rd = 1'b0;
        m_en = 0; m_ptr = 2'd3; m_rpt = 0;
        chk_cfg("R13");

        // Seeded random sweep over codes and times
        for (int it = 0; it < 240; it++) begin
            if (it % 8 == 0)
                set_alarm(rbcd(59), rbcd(59), rbcd(23), rbcd(6), rbcd(31), rbcd(12));
            cfg_set(($urandom % 10) != 0, $urandom % 2, 2'd0,
                    4'($urandom_range(0, 15)), 8'($urandom_range(0, 2)));
            for (int k = 0; k < 3; k++) begin
                int sel;
                f[0] = m_lo[0]; f[1] = m_hi[0]; f[2] = m_lo[1];
                f[3] = m_hi[1]; f[4] = m_lo[2]; f[5] = m_hi[2];
                sel = $urandom_range(0, 8);
                if (sel < 6) f[sel] = f[sel] ^ 8'(1 << $urandom_range(0, 7));
                set_now(f[0], f[1], f[2], f[3], f[4], f[5], 1'($urandom % 3 == 0));
                if (m_gran <= 4'd1)      do_tick("R3");
                else if (m_gran <= 4'd5) do_tick("R4");
                else if (m_gran <= 4'd9) do_tick("R5");
                else                     do_tick("R6");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule